// File: doc/BRIEF.md
# Render-Time Scroll Address Updater

This block owns the 15-bit current video address while the background is being drawn. It is fed the dot counter, a flag for the line just before the visible picture, a rendering-enable flag, the temporary address loaded by the CPU side, and a strobe for each tile advance. From these it steps the horizontal tile position, steps the vertical position (fine row, then tile row) with nametable-page wrapping, and reloads all or part of the address from the temporary copy at fixed dots.

The address is kept in one register. Two fetch addresses are decoded from it without further registers: the nametable tile address and the attribute byte address. A separate vertical-step request from the data port is merged with the dot-timed one, so that the address steps only once when both occur.

The register is split into fields. Bits 14:12 hold the fine row. Bit 11 selects the vertical page and bit 10 the horizontal page. Bits 9:5 hold the tile row and bits 4:0 the tile column.

Top module: `scroll_addr_updater`

## Requirements
- R1: While reset is high, the address reads 0. It stays 0 after reset until a rule below changes it.
- R2: When rendering is enabled, a tile-advance strobe adds 1 to bits 4:0. When bits 4:0 are 31, the strobe clears them to 0 and inverts bit 10. This applies on any dot outside the window of R3, including dot 256 and dot 320.
- R3: A tile-advance strobe on dots 257 to 319 has no effect on the address.
- R4: When rendering is enabled, dot 250 of every line triggers a vertical step. If the fine row (bits 14:12) is below 7, the step adds 1 to it. Otherwise it clears the fine row and steps the tile row as in R5.
- R5: A tile-row step works on bits 9:5. A value of 29 becomes 0 and inverts bit 11. A value of 31 becomes 0 and leaves bit 11 unchanged. Any other value increases by 1.
- R6: When rendering is enabled, dot 256 copies bit 10 and bits 4:0 from the temporary address. All other bits keep their values, apart from any vertical step from the same cycle.
- R7: When rendering is enabled, dot 304 of the pre-render line loads the whole address from the temporary address. This load overrides every other update in that cycle.
- R8: While rendering is disabled, the address holds its value, whatever the dot, strobe, request or temporary-address inputs are.
- R9: When rendering is enabled, a port vertical-step request applies the R4 step in the same clock. If the request falls on dot 250, the address steps only once.
- R10: The tile fetch address (14 bits) equals 0x2000 OR bits 11:0 of the address.
- R11: The attribute fetch address (14 bits) equals 0x23C0 OR (address AND 0x0C00) OR ((address >> 4) AND 0x38) OR ((address >> 2) AND 0x07).
- R12: Dot 304 on a line other than the pre-render line performs no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot | input | DOT_W (9) | Current dot within the line |
| prerender | input | 1 | High during the pre-render line |
| render_en | input | 1 | Background or sprite rendering enabled |
| t_addr | input | 15 | Temporary address from the CPU side |
| tile_adv | input | 1 | Tile-advance strobe |
| port_vstep | input | 1 | Vertical-step request from the data port |
| v_addr | output | 15 | Current address register |
| tile_addr | output | 14 | Nametable tile fetch address |
| attr_addr | output | 14 | Attribute fetch address |

## Verification
Every input sampled at a rising edge has its effect on `v_addr` exactly one clock later, because only one register lies between the inputs and the address. The two fetch addresses are decoded from `v_addr` with no register, so they are due in the same cycle as the address they come from. The bench drives inputs on the falling edge and works out the next address from a behavioural model. After the next rising edge it compares all three outputs on the following falling edge. This keeps every comparison one full register stage after its stimulus, and well away from any edge.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

    localparam int V_W    = 15;
    localparam int FA_W   = 14;
    localparam int DOT_DW = 9;

    localparam int DOT_VSTEP = 250;
    localparam int DOT_HCOPY = 256;
    localparam int DOT_FULL  = 304;
    localparam int HBL_LAST  = 319;

    localparam logic [4:0] ROW_LAST  = 5'd29;
    localparam logic [4:0] ROW_MAX   = 5'd31;
    localparam logic [4:0] COL_MAX   = 5'd31;
    localparam logic [2:0] FINE_MAX  = 3'd7;

    typedef struct packed {
        logic [2:0] fine_y;
        logic       page_v;
        logic       page_h;
        logic [4:0] coarse_y;
        logic [4:0] coarse_x;
    } vaddr_t;

    function automatic vaddr_t step_col(vaddr_t a);
        vaddr_t r = a;
        if (a.coarse_x == COL_MAX) begin
            r.coarse_x = '0;
            r.page_h   = ~a.page_h;
        end else begin
            r.coarse_x = a.coarse_x + 5'd1;
        end
        return r;
    endfunction

    function automatic vaddr_t step_vert(vaddr_t a);
        vaddr_t r = a;
        if (a.fine_y != FINE_MAX) begin
            r.fine_y = a.fine_y + 3'd1;
        end else begin
            r.fine_y = '0;
            if (a.coarse_y == ROW_LAST) begin
                r.coarse_y = '0;
                r.page_v   = ~a.page_v;
            end else if (a.coarse_y == ROW_MAX) begin
                r.coarse_y = '0;
            end else begin
                r.coarse_y = a.coarse_y + 5'd1;
            end
        end
        return r;
    endfunction

    function automatic vaddr_t copy_horiz(vaddr_t a, vaddr_t src);
        vaddr_t r = a;
        r.page_h   = src.page_h;
        r.coarse_x = src.coarse_x;
        return r;
    endfunction

endpackage

// File: rtl/scroll_step.sv
module scroll_step
    import scroll_pkg::*;
#(
    parameter int DOT_W = DOT_DW
) (
    input  vaddr_t           cur,
    input  vaddr_t           tmp,
    input  logic [DOT_W-1:0] dot,
    input  logic             prerender,
    input  logic             render_en,
    input  logic             tile_adv,
    input  logic             port_vstep,
    output vaddr_t           nxt
);
    localparam logic [DOT_W-1:0] D_VSTEP = DOT_W'(DOT_VSTEP);
    localparam logic [DOT_W-1:0] D_HCOPY = DOT_W'(DOT_HCOPY);
    localparam logic [DOT_W-1:0] D_FULL  = DOT_W'(DOT_FULL);
    localparam logic [DOT_W-1:0] D_HBL_L = DOT_W'(HBL_LAST);

    logic in_hblank;
    logic do_col, do_vert, do_hcopy, do_full;
    vaddr_t s_col, s_vert;

    always_comb begin
        in_hblank = (dot > D_HCOPY) && (dot <= D_HBL_L);
        do_full   = render_en && prerender && (dot == D_FULL);
        do_col    = render_en && tile_adv && !in_hblank;
        do_vert   = render_en && ((dot == D_VSTEP) || port_vstep);
        do_hcopy  = render_en && (dot == D_HCOPY);

        s_col  = do_col  ? step_col(cur)    : cur;
        s_vert = do_vert ? step_vert(s_col) : s_col;

        if (do_full)
            nxt = tmp;
        else if (do_hcopy)
            nxt = copy_horiz(s_vert, tmp);
        else
            nxt = s_vert;
    end
endmodule

// File: rtl/scroll_fetch_addr.sv
module scroll_fetch_addr
    import scroll_pkg::*;
(
    input  vaddr_t          cur,
    output logic [FA_W-1:0] tile_addr,
    output logic [FA_W-1:0] attr_addr
);
    localparam logic [1:0] NT_BASE = 2'b10;
    localparam logic [3:0] ATTR_OFS = 4'b1111;

    always_comb begin
        tile_addr = {NT_BASE, cur.page_v, cur.page_h, cur.coarse_y, cur.coarse_x};
        attr_addr = {NT_BASE, cur.page_v, cur.page_h, ATTR_OFS,
                     cur.coarse_y[4:2], cur.coarse_x[4:2]};
    end
endmodule

// File: rtl/scroll_addr_updater.sv
module scroll_addr_updater
    import scroll_pkg::*;
#(
    parameter int DOT_W = DOT_DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DOT_W-1:0] dot,
    input  logic             prerender,
    input  logic             render_en,
    input  logic [V_W-1:0]   t_addr,
    input  logic             tile_adv,
    input  logic             port_vstep,
    output logic [V_W-1:0]   v_addr,
    output logic [FA_W-1:0]  tile_addr,
    output logic [FA_W-1:0]  attr_addr
);
    vaddr_t v_q, v_d;

    scroll_step #(.DOT_W(DOT_W)) u_step (
        .cur        (v_q),
        .tmp        (vaddr_t'(t_addr)),
        .dot        (dot),
        .prerender  (prerender),
        .render_en  (render_en),
        .tile_adv   (tile_adv),
        .port_vstep (port_vstep),
        .nxt        (v_d)
    );

    scroll_fetch_addr u_fetch (
        .cur       (v_q),
        .tile_addr (tile_addr),
        .attr_addr (attr_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= v_d;
    end

    assign v_addr = v_q;
endmodule

// File: rtl/scroll_addr_updater_chk.sv
module scroll_addr_updater_chk
    import scroll_pkg::*;
#(
    parameter int DOT_W = DOT_DW
) (
    input logic             clk,
    input logic             rst,
    input logic [DOT_W-1:0] dot,
    input logic             prerender,
    input logic             render_en,
    input logic [V_W-1:0]   t_addr,
    input logic             tile_adv,
    input logic             port_vstep,
    input logic [V_W-1:0]   v_addr,
    input logic [FA_W-1:0]  tile_addr,
    input logic [FA_W-1:0]  attr_addr
);
    logic full_now, hbl_now, quiet_vert;
    assign full_now   = prerender && (dot == DOT_W'(DOT_FULL));
    assign hbl_now    = (dot > DOT_W'(DOT_HCOPY)) && (dot <= DOT_W'(HBL_LAST));
    assign quiet_vert = (dot != DOT_W'(DOT_VSTEP)) && !port_vstep;

    always_ff @(posedge clk) begin
        if (rst) assert_reset_zero_R1: assert (v_addr == '0 || $past(rst) == 1'b0);
    end

    assert_col_step_R2: assert property (@(posedge clk) disable iff (rst)
        render_en && tile_adv && !hbl_now && !full_now && (dot != DOT_W'(DOT_HCOPY))
        && (v_addr[4:0] != 5'd31)
        |=> v_addr[4:0] == $past(v_addr[4:0]) + 5'd1);

    assert_hblank_col_hold_R3: assert property (@(posedge clk) disable iff (rst)
        render_en && hbl_now && !full_now
        |=> v_addr[4:0] == $past(v_addr[4:0]) && v_addr[10] == $past(v_addr[10]));

    assert_fine_step_R4: assert property (@(posedge clk) disable iff (rst)
        render_en && !full_now && !quiet_vert && (v_addr[14:12] != 3'd7)
        |=> v_addr[14:12] == $past(v_addr[14:12]) + 3'd1);

    assert_row_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        render_en && !full_now && !quiet_vert && (v_addr[14:12] == 3'd7)
        && (v_addr[9:5] == 5'd29)
        |=> v_addr[9:5] == 5'd0 && v_addr[11] != $past(v_addr[11]));

    assert_hcopy_R6: assert property (@(posedge clk) disable iff (rst)
        render_en && (dot == DOT_W'(DOT_HCOPY))
        |=> v_addr[10] == $past(t_addr[10]) && v_addr[4:0] == $past(t_addr[4:0]));

    assert_full_copy_R7: assert property (@(posedge clk) disable iff (rst)
        render_en && full_now |=> v_addr == $past(t_addr));

    assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !render_en |=> $stable(v_addr));

    assert_no_copy_R12: assert property (@(posedge clk) disable iff (rst)
        render_en && !prerender && (dot == DOT_W'(DOT_FULL)) && !tile_adv && quiet_vert
        |=> $stable(v_addr));

    always_comb begin
        assert_attr_const_R11: assert (attr_addr[13:6] == {2'b10, v_addr[11:10], 4'b1111});
        assert_tile_page_R10: assert (tile_addr[13:12] == 2'b10);
    end
endmodule

bind scroll_addr_updater scroll_addr_updater_chk #(.DOT_W(DOT_W)) u_chk (
    .clk(clk), .rst(rst), .dot(dot), .prerender(prerender), .render_en(render_en),
    .t_addr(t_addr), .tile_adv(tile_adv), .port_vstep(port_vstep),
    .v_addr(v_addr), .tile_addr(tile_addr), .attr_addr(attr_addr)
);

// File: tb/scroll_addr_updater_tb.sv
module scroll_addr_updater_tb;
    logic        clk = 0;
    logic        rst;
    logic [8:0]  dot;
    logic        prerender, render_en, tile_adv, port_vstep;
    logic [14:0] t_addr;
    logic [14:0] v_addr;
    logic [13:0] tile_addr, attr_addr;

    int n_tests = 0;
    int n_fail  = 0;
    int model   = 0;

    always #5 clk = ~clk;

    scroll_addr_updater u_dut (
        .clk(clk), .rst(rst), .dot(dot), .prerender(prerender), .render_en(render_en),
        .t_addr(t_addr), .tile_adv(tile_adv), .port_vstep(port_vstep),
        .v_addr(v_addr), .tile_addr(tile_addr), .attr_addr(attr_addr)
    );

    function automatic int ref_next(int v, int d, bit pre, bit en, int t, bit adv, bit vs);
        int r = v;
        int fy, cy;
        if (!en) return v;
        if (pre && d == 304) return t;
        if (adv && !(d > 256 && d < 320)) begin
            if (r % 32 == 31) r = (r - 31) ^ 1024;
            else              r = r + 1;
        end
        if (d == 250 || vs) begin
            fy = (r >> 12) & 7;
            if (fy < 7) r = r + 4096;
            else begin
                r  = r - 7 * 4096;
                cy = (r >> 5) & 31;
                r  = r - cy * 32;
                if (cy == 29)      begin cy = 0; r = r ^ 2048; end
                else if (cy == 31) cy = 0;
                else               cy = cy + 1;
                r = r + cy * 32;
            end
        end
        if (d == 256) r = (r & ~32'h41F) | (t & 32'h41F);
        return r & 32'h7FFF;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        int ta, aa;
        ta = 32'h2000 | (model & 32'hFFF);
        aa = 32'h23C0 | (model & 32'h0C00) | ((model >> 4) & 32'h38) | ((model >> 2) & 32'h07);
        check(tag, int'(v_addr), model);
        check("R10 tile", int'(tile_addr), ta);
        check("R11 attr", int'(attr_addr), aa);
    endtask

    task automatic step(int d, bit pre, bit en, int t, bit adv, bit vs, string tag);
        dot = 9'(d); prerender = pre; render_en = en; t_addr = 15'(t);
        tile_adv = adv; port_vstep = vs;
        model = ref_next(model, d, pre, en, t, adv, vs);
        @(posedge clk);
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic load(int t);
        step(304, 1, 1, t, 0, 0, "R7 full copy");
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1; dot = 0; prerender = 0; render_en = 1; t_addr = 15'h7FFF;
        tile_adv = 1; port_vstep = 1;
        repeat (3) @(negedge clk);
        model = 0;
        check_outputs("R1 reset");
        rst = 0;
        step(10, 0, 0, 32'h7FFF, 1, 1, "R1 hold after reset");

        // R2 column step and wrap
        load(32'h001E);
        step(100, 0, 1, 0, 1, 0, "R2 col +1");
        step(100, 0, 1, 0, 1, 0, "R2 col wrap");
        check("R2 page_h toggled", int'(v_addr), 32'h0400);

        // R3 blanking window
        load(32'h0005);
        step(300, 0, 1, 0, 1, 0, "R3 hblank");
        step(257, 0, 1, 0, 1, 0, "R3 hblank start");
        step(319, 0, 1, 0, 1, 0, "R3 hblank end");
        step(320, 0, 1, 0, 1, 0, "R2 dot 320");

        // R4 / R5 vertical steps
        load(32'h6000 | (29 << 5));
        step(250, 0, 1, 0, 0, 0, "R4 fine +1");
        step(250, 0, 1, 0, 0, 0, "R5 row 29 wrap");
        check("R5 page_v toggled", int'(v_addr), 32'h0800);
        load(32'h7000 | (31 << 5));
        step(250, 0, 1, 0, 0, 0, "R5 row 31 wrap");
        load(32'h7000 | (10 << 5));
        step(250, 0, 1, 0, 0, 0, "R5 row +1");

        // R9 port request
        load(32'h1000);
        step(250, 0, 1, 0, 0, 1, "R9 coincide single step");
        step(100, 0, 1, 0, 0, 1, "R9 port step");

        // R6 horizontal copy
        load(32'h7BE0);
        step(256, 0, 1, 32'h0403, 1, 0, "R6 hcopy");

        // R8 disabled
        load(32'h1234);
        step(250, 1, 0, 32'h7FFF, 1, 1, "R8 disabled");
        step(304, 1, 0, 32'h7FFF, 1, 0, "R8 disabled full");
        step(256, 0, 0, 32'h7FFF, 0, 0, "R8 disabled hcopy");

        // R12 non-prerender dot 304
        step(304, 0, 1, 32'h7FFF, 0, 0, "R12 no copy");

        // R10 / R11 extreme address
        load(32'h7FFF);
        load(32'h0C00 | (28 << 5) | 20);

        // mixed patterns against the model
        for (int i = 0; i < 400; i++) begin
            int d, tt; bit pr, en, ad, vs;
            case ($urandom_range(0, 5))
                0: d = 250;
                1: d = 256;
                2: d = 304;
                default: d = $urandom_range(0, 340);
            endcase
            pr = ($urandom_range(0, 3) == 0);
            en = ($urandom_range(0, 7) != 0);
            ad = $urandom_range(0, 1);
            vs = ($urandom_range(0, 5) == 0);
            tt = $urandom_range(0, 32767);
            if (!en)                   step(d, pr, en, tt, ad, vs, "R8 mix");
            else if (pr && d == 304)   step(d, pr, en, tt, ad, vs, "R7 mix");
            else if (d == 256)         step(d, pr, en, tt, ad, vs, "R6 mix");
            else if (d == 250 || vs)   step(d, pr, en, tt, ad, vs, "R4 mix");
            else                       step(d, pr, en, tt, ad, vs, "R2 mix");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule